// File: doc/BRIEF.md
# Programmable channel input combiner

This block is the digital control path for a bank of low-side output channels. Each channel has a parallel input pin, and the pin's active level is fixed by a strap pin. After qualification, the pin is merged with a data bit written over the serial control port. The merge uses a Boolean operator that software programs as OR or AND. A per-channel over-temperature flag cuts the channel off at once. The channel turns back on only after a separate cool-down flag reports that the temperature has dropped below the restart level, so the thermal hysteresis lives in logic.

The pins and the strap are asynchronous, so each passes through a two-flop synchronizer. Commands arrive as a valid-qualified 4-bit code with a 4-bit data field, already deserialized by the serial port. The thermal flags come from on-chip comparators, are synchronous to the clock, and are used without filtering. The gate-enable outputs are registered.

Top module: `lsd_input_combiner`

## Requirements
- R1: While rst_ni is low, and on the first clock edge after it is released, every gate_o bit is 0. Reset clears all command data bits to 0 and selects the OR operator.
- R2: With pol_hi_i at 1 a pin is asserted when high. With pol_hi_i at 0 a pin is asserted when low.
- R3: pin_i[n] and cmd data bit n affect only gate_o[n].
- R4: In OR mode, gate_o[n] is the qualified pin n OR data bit n, unless the channel is thermally shut down.
- R5: In AND mode, gate_o[n] is the qualified pin n AND data bit n, unless the channel is thermally shut down.
- R6: An accepted command with code 4'b0011 loads the data field and selects OR. Code 4'b1111 loads the data field and selects AND.
- R7: An accepted command with any code other than 4'b0011, 4'b1111, 4'b0000, 4'b1100 or 4'b1010 loads the data field and leaves the operator unchanged.
- R8: Codes 4'b0000, 4'b1100 and 4'b1010 change neither the data bits nor the operator.
- R9: ot_hot_i[n] high at a clock edge forces gate_o[n] to 0 at that same edge, whatever the pin and data.
- R10: Once ot_hot_i[n] has been seen, channel n stays off until an edge where ot_cool_i[n] is 1 and ot_hot_i[n] is 0. At that edge the channel resumes.
- R11: A change on pin_i or pol_hi_i reaches gate_o on the third clock edge. An accepted command reaches gate_o on the second edge.
- R12: With cmd_valid_i low, cmd_code_i and cmd_data_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (sleep) |
| pin_i | input | 4 | Parallel channel input pins, asynchronous |
| pol_hi_i | input | 1 | Strap: 1 active-high pins, 0 active-low pins |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_code_i | input | 4 | Command code |
| cmd_data_i | input | 4 | Command data field, bit n for channel n |
| ot_hot_i | input | 4 | Per-channel over-temperature comparator flag |
| ot_cool_i | input | 4 | Per-channel below-restart comparator flag |
| gate_o | output | 4 | Registered per-channel gate enable |

## Verification
The assertions assume that the thermal flags and the command strobe are synchronous to clk_i and are sampled once per edge. They also assume that a pin which is stable long enough settles through the synchronizer without metastability. The stimulus changes every input only on the falling clock edge. It holds the strap pin for long stretches, so the cycle-counted stability check has quiet windows to fire in. Thermal flags are drawn at low rates, and hot and cool are sometimes raised together. The command codes are drawn to cover the two operator codes, the three passive codes and the rest.

// File: rtl/lsd_comb_pkg.sv
package lsd_comb_pkg;
  localparam int unsigned CMD_W = 4;

  typedef enum logic {
    OP_OR  = 1'b0,
    OP_AND = 1'b1
  } bool_op_e;

  localparam logic [CMD_W-1:0] CODE_DIAG     = 4'b0000;
  localparam logic [CMD_W-1:0] CODE_READBACK = 4'b1100;
  localparam logic [CMD_W-1:0] CODE_ECHO     = 4'b1010;
  localparam logic [CMD_W-1:0] CODE_SET_OR   = 4'b0011;
  localparam logic [CMD_W-1:0] CODE_SET_AND  = 4'b1111;

  function automatic logic code_is_passive(input logic [CMD_W-1:0] c);
    return (c == CODE_DIAG) || (c == CODE_READBACK) || (c == CODE_ECHO);
  endfunction
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lsd_cmd_decode.sv
module lsd_cmd_decode
  import lsd_comb_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CMD_W-1:0] code_i,
  input  logic [NCH-1:0]   data_i,
  output logic [NCH-1:0]   data_o,
  output bool_op_e         op_o
);
  logic [NCH-1:0] data_q, data_d;
  bool_op_e       op_q, op_d;

  always_comb begin
    data_d = data_q;
    op_d   = op_q;
    if (valid_i) begin
      if (code_i == CODE_SET_OR) begin
        data_d = data_i;
        op_d   = OP_OR;
      end else if (code_i == CODE_SET_AND) begin
        data_d = data_i;
        op_d   = OP_AND;
      end else if (!code_is_passive(code_i)) begin
        data_d = data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      op_q   <= OP_OR;
    end else begin
      data_q <= data_d;
      op_q   <= op_d;
    end
  end

  assign data_o = data_q;
  assign op_o   = op_q;
endmodule

// File: rtl/lsd_thermal_latch.sv
module lsd_thermal_latch #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hot_i,
  input  logic [NCH-1:0] cool_i,
  output logic [NCH-1:0] shut_o
);
  logic [NCH-1:0] shut_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // hot wins over cool; output reflects the current edge's hot flag
    assign shut_o[n] = hot_i[n] | (shut_q[n] & ~cool_i[n]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shut_q[n] <= 1'b0;
      else         shut_q[n] <= shut_o[n];
    end
  end
endmodule

// File: rtl/lsd_input_combiner.sv
module lsd_input_combiner
  import lsd_comb_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   pin_i,
  input  logic             pol_hi_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic [NCH-1:0]   cmd_data_i,
  input  logic [NCH-1:0]   ot_hot_i,
  input  logic [NCH-1:0]   ot_cool_i,
  output logic [NCH-1:0]   gate_o
);
  localparam int unsigned SYNC_W = NCH + 1;

  logic [SYNC_W-1:0] raw_in, sync_out;
  logic [NCH-1:0]    pin_s;
  logic              pol_s;
  logic [NCH-1:0]    data_bits;
  bool_op_e          op_sel;
  logic [NCH-1:0]    shut;
  logic [NCH-1:0]    qual, merged, gate_d, gate_q;

  assign raw_in = {pol_hi_i, pin_i};

  lsd_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({1'b1, {NCH{1'b0}}})
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_out)
  );

  assign pin_s = sync_out[NCH-1:0];
  assign pol_s = sync_out[NCH];

  lsd_cmd_decode #(.NCH(NCH)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cmd_valid_i),
    .code_i  (cmd_code_i),
    .data_i  (cmd_data_i),
    .data_o  (data_bits),
    .op_o    (op_sel)
  );

  lsd_thermal_latch #(.NCH(NCH)) u_therm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hot_i  (ot_hot_i),
    .cool_i (ot_cool_i),
    .shut_o (shut)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign qual[n]   = pol_s ? pin_s[n] : ~pin_s[n];
    assign merged[n] = (op_sel == OP_AND) ? (qual[n] & data_bits[n])
                                          : (qual[n] | data_bits[n]);
    assign gate_d[n] = merged[n] & ~shut[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/lsd_input_combiner_chk.sv
module lsd_input_combiner_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] pin_i,
  input logic           pol_hi_i,
  input logic           cmd_valid_i,
  input logic [NCH-1:0] ot_hot_i,
  input logic [NCH-1:0] ot_cool_i,
  input logic [NCH-1:0] gate_o
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 3'd5) cyc_q <= cyc_q + 3'd1;
  end

  // R1: outputs still cleared at the first edge after release
  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 3'd0) |-> (gate_o == '0));

  // R9: hot flag cuts the channel at the same edge
  assert_hot_cutoff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_hot_i != '0) |=> ((gate_o & $past(ot_hot_i)) == '0));

  // R11: quiet inputs leave the outputs stable
  assert_quiet_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_q == 3'd5) &&
     $past(pin_i, 3) == $past(pin_i, 4) && $past(pol_hi_i, 3) == $past(pol_hi_i, 4) &&
     !$past(cmd_valid_i, 2) && !$past(cmd_valid_i, 3) &&
     $past(ot_hot_i, 1) == '0 && $past(ot_hot_i, 2) == '0 &&
     $past(ot_cool_i, 1) == '1 && $past(ot_cool_i, 2) == '1) |-> $stable(gate_o));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R10: shutdown holds until cool
    assert_hold_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cyc_q != 3'd0) && $past(ot_hot_i[n]) && !ot_cool_i[n]) |=> !gate_o[n]);
    // R10: no turn-on right after a hot edge
    assert_no_rise_hot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cyc_q >= 3'd2) && $rose(gate_o[n])) |-> !$past(ot_hot_i[n], 1));
  end
endmodule

bind lsd_input_combiner lsd_input_combiner_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_i       (pin_i),
  .pol_hi_i    (pol_hi_i),
  .cmd_valid_i (cmd_valid_i),
  .ot_hot_i    (ot_hot_i),
  .ot_cool_i   (ot_cool_i),
  .gate_o      (gate_o)
);

// File: tb/tb_lsd_input_combiner.sv
module tb_lsd_input_combiner;
  localparam int NCH = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NCH-1:0] pin_i = '0;
  logic           pol_hi_i = 1'b1;
  logic           cmd_valid_i = 1'b0;
  logic [3:0]     cmd_code_i = '0;
  logic [NCH-1:0] cmd_data_i = '0;
  logic [NCH-1:0] ot_hot_i = '0;
  logic [NCH-1:0] ot_cool_i = '1;
  logic [NCH-1:0] gate_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lsd_input_combiner dut (
    .clk_i, .rst_ni, .pin_i, .pol_hi_i, .cmd_valid_i,
    .cmd_code_i, .cmd_data_i, .ot_hot_i, .ot_cool_i, .gate_o
  );

  // Reference model built from the requirement timings
  logic [NCH-1:0] m_p1, m_p2, m_data, m_shut, m_exp;
  logic           m_o1, m_o2, m_and;

  function automatic logic [NCH-1:0] ref_gate(input logic [NCH-1:0] p, input logic pol,
                                              input logic [NCH-1:0] d, input logic and_op,
                                              input logic [NCH-1:0] off);
    logic [NCH-1:0] q;
    q = pol ? p : ~p;
    return (and_op ? (q & d) : (q | d)) & ~off;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_p1 = '0; m_p2 = '0; m_o1 = 1'b1; m_o2 = 1'b1;
      m_data = '0; m_and = 1'b0; m_shut = '0; m_exp = '0;
    end else begin
      logic [NCH-1:0] nshut;
      nshut = ot_hot_i | (m_shut & ~ot_cool_i);
      m_exp = ref_gate(m_p2, m_o2, m_data, m_and, nshut);
      m_shut = nshut;
      m_p2 = m_p1; m_p1 = pin_i;
      m_o2 = m_o1; m_o1 = pol_hi_i;
      if (cmd_valid_i) begin
        case (cmd_code_i)
          4'b0011: begin m_data = cmd_data_i; m_and = 1'b0; end
          4'b1111: begin m_data = cmd_data_i; m_and = 1'b1; end
          4'b0000, 4'b1100, 4'b1010: ;
          default: m_data = cmd_data_i;
        endcase
      end
    end
  end

  task automatic chk(input string tag);
    n_vec++;
    if (gate_o !== m_exp) begin
      n_bad++;
      $display("FAIL %s: gate_o=%b expected=%b at %0t", tag, gate_o, m_exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag);
  endtask

  task automatic cmd(input logic [3:0] c, input logic [NCH-1:0] d, input string tag);
    cmd_valid_i = 1'b1; cmd_code_i = c; cmd_data_i = d;
    tick(tag);
    cmd_valid_i = 1'b0;
    tick(tag);
  endtask

  task automatic settle(input string tag);
    for (int i = 0; i < 4; i++) tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: reset state
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (gate_o !== '0) begin
      n_bad++;
      $display("FAIL R1: gate_o=%b expected=0000 in reset", gate_o);
    end
    pin_i = 4'b1111; pol_hi_i = 1'b0; // active-low idle pins are off
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick("R1");
    settle("R1");

    // R2: active-low then active-high
    pin_i = 4'b0110;
    settle("R2");
    pol_hi_i = 1'b1;
    settle("R2");

    // R11: pin rise reaches gate on the third edge
    pin_i = 4'b0000;
    settle("R11");
    pin_i = 4'b1000;
    tick("R11"); tick("R11"); tick("R11"); tick("R11");

    // R3: single pin toggles
    for (int n = 0; n < NCH; n++) begin
      pin_i = 4'b0001 << n;
      settle("R3");
    end

    // R4 / R6: OR with data
    pin_i = 4'b0011;
    cmd(4'b0011, 4'b0100, "R6");
    settle("R4");
    // R5 / R6: AND with data
    cmd(4'b1111, 4'b0110, "R6");
    settle("R5");
    // R7: plain data write keeps AND
    cmd(4'b0101, 4'b0011, "R7");
    settle("R7");
    // R8: passive codes
    cmd(4'b0000, 4'b1100, "R8");
    cmd(4'b1100, 4'b1100, "R8");
    cmd(4'b1010, 4'b1100, "R8");
    settle("R8");
    // R12: strobe low ignores code and data
    cmd_code_i = 4'b0011; cmd_data_i = 4'b1111;
    settle("R12");
    cmd(4'b0011, 4'b0000, "R6");

    // R9 / R10: thermal shutdown and restart
    pin_i = 4'b1111;
    settle("R9");
    ot_cool_i = 4'b0000; ot_hot_i = 4'b0101;
    tick("R9");
    ot_hot_i = 4'b0000;
    settle("R10");
    ot_cool_i = 4'b0001; ot_hot_i = 4'b0100; // hot wins on ch2
    tick("R10");
    ot_hot_i = 4'b0000; ot_cool_i = 4'b1111;
    settle("R10");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      pin_i = NCH'($urandom);
      if ($urandom_range(0, 31) == 0) pol_hi_i = ~pol_hi_i;
      cmd_valid_i = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 3))
        0: cmd_code_i = 4'b0011;
        1: cmd_code_i = 4'b1111;
        2: cmd_code_i = ($urandom_range(0, 1) != 0) ? 4'b1100 : 4'b1010;
        default: cmd_code_i = 4'($urandom);
      endcase
      cmd_data_i = NCH'($urandom);
      for (int n = 0; n < NCH; n++) begin
        ot_hot_i[n]  = ($urandom_range(0, 19) == 0);
        ot_cool_i[n] = ($urandom_range(0, 3) != 0);
      end
      if ($urandom_range(0, 7) == 0) begin
        ot_hot_i = '0; ot_cool_i = '1;
      end
      tick("R4/R5/R7/R10 random");
    end
    finish_run();
  end
endmodule